// File: doc/BRIEF.md
# Register Scoreboard Hazard Unit

This block decides, in the same cycle an instruction is offered for issue, whether that instruction may enter an in-order execution pipeline. It keeps its own shadow pipeline of destination tags, one entry per stage, each holding a valid flag and a register index. Every cycle each stage's tag is decoded into a one-hot mask over the register file. The masks are then combined with OR to show which registers still have a result pending.

An offered instruction is held (stall) when it reads a register that a stage before the last still has to write. It is also held when its own destination is already pending anywhere in the pipe, so two writers of one register are never in flight together. A source whose only pending writer sits in the last execution stage is not held. Instead, a per-operand forward select is raised, so that the operand is taken from that stage's result. A held instruction enters the shadow pipe as a bubble while the older entries keep moving. Register 0 is hard-wired and never counts as pending. Instructions that write no register still occupy a stage, but they mark nothing as pending.

Top module: `hz_scoreboard`

## Requirements
- R1: Reset (synchronous, active high) empties every stage. After reset, any offered instruction issues with stall and both forward selects low.
- R2: When an offered instruction has a nonzero source index that equals the destination of a valid writing entry in any stage except the last, stall is high in that same cycle.
- R3: When a nonzero source matches only the last stage's destination, the forward select for that source (fwd_rs1 or fwd_rs2) is high in the same cycle, and that source alone does not cause a stall.
- R4: When an offered writing instruction has a nonzero destination equal to the destination of any valid writing entry in any stage, including the last, stall is high.
- R5: Register index 0 never marks a register as pending and never stalls. An instruction with issue_wr low occupies a stage but marks no register as pending.
- R6: A stalled or non-valid offer enters the first stage as a bubble, so the destination of a stalled instruction never becomes pending.
- R7: Entries advance one stage per clock even while issue is stalled. With DEPTH=8, a dependent reader offered on each following cycle stalls on exactly the 7 cycles after its producer issues, and is forwarded on the 8th.
- R8: While issue_valid is low, stall, fwd_rs1 and fwd_rs2 are all low.
- R9: The two sources are judged independently. One source can be forwarded while the other causes a stall in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An instruction is offered for issue |
| issue_rs1 | input | 5 | First source register index (0 = unused) |
| issue_rs2 | input | 5 | Second source register index (0 = unused) |
| issue_rd | input | 5 | Destination register index |
| issue_wr | input | 1 | Offered instruction writes issue_rd |
| stall | output | 1 | Hold the offered instruction this cycle |
| fwd_rs1 | output | 1 | Take source 1 from the last-stage result |
| fwd_rs2 | output | 1 | Take source 2 from the last-stage result |

## Verification
A reader is offered on every cycle after its producer. This pattern separates a tag that sits in an early stage (stall) from a tag in the last stage (forward) and from a tag that has retired (free), and it also shows that the shadow pipe keeps moving while stalled. Repeated writers of one register separate the write-after-write check, which also covers the last stage, from the read check. Offers that use register 0, offers with issue_wr low, and offers whose earlier attempts were stalled show that nothing becomes pending without an accepted write. A case with one source forwarded and the other blocked, together with offers where issue_valid is low, shows that each operand is judged on its own and that every output is gated by validity.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int unsigned HZ_DEF_NUM_REGS = 32;
  localparam int unsigned HZ_DEF_DEPTH    = 8;

  typedef enum logic [1:0] {
    HZ_CLEAR = 2'd0,
    HZ_RAW   = 2'd1,
    HZ_WAW   = 2'd2
  } hz_cause_e;
endpackage

// File: rtl/hz_dst_decode.sv
module hz_dst_decode #(
  parameter int unsigned NUM_REGS = hz_pkg::HZ_DEF_NUM_REGS,
  parameter int unsigned IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                en,
  input  logic [IDX_W-1:0]    idx,
  output logic [NUM_REGS-1:0] mask
);
  // Bit 0 is the hard-wired zero register: never pending.
  assign mask[0] = 1'b0;
  for (genvar b = 1; b < NUM_REGS; b++) begin : g_bit
    assign mask[b] = en && (idx == IDX_W'(b));
  end
endmodule

// File: rtl/hz_tag_pipe.sv
module hz_tag_pipe #(
  parameter int unsigned DEPTH = hz_pkg::HZ_DEF_DEPTH,
  parameter int unsigned IDX_W = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_vld,
  input  logic                        in_wr,
  input  logic [IDX_W-1:0]            in_dst,
  output logic [DEPTH-1:0]            stg_vld,
  output logic [DEPTH-1:0]            stg_wr,
  output logic [DEPTH-1:0][IDX_W-1:0] stg_dst
);
  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    logic             nxt_vld;
    logic             nxt_wr;
    logic [IDX_W-1:0] nxt_dst;
    if (s == 0) begin : g_head
      assign nxt_vld = in_vld;
      assign nxt_wr  = in_vld && in_wr;
      assign nxt_dst = (in_vld && in_wr) ? in_dst : '0;
    end else begin : g_body
      assign nxt_vld = stg_vld[s-1];
      assign nxt_wr  = stg_wr[s-1];
      assign nxt_dst = stg_dst[s-1];
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        stg_vld[s] <= 1'b0;
        stg_wr[s]  <= 1'b0;
        stg_dst[s] <= '0;
      end else begin
        stg_vld[s] <= nxt_vld;
        stg_wr[s]  <= nxt_wr;
        stg_dst[s] <= nxt_dst;
      end
    end
  end
endmodule

// File: rtl/hz_busy_merge.sv
module hz_busy_merge #(
  parameter int unsigned NUM_REGS = hz_pkg::HZ_DEF_NUM_REGS,
  parameter int unsigned IDX_W    = $clog2(NUM_REGS),
  parameter int unsigned DEPTH    = hz_pkg::HZ_DEF_DEPTH
) (
  input  logic [DEPTH-1:0]            stg_vld,
  input  logic [DEPTH-1:0]            stg_wr,
  input  logic [DEPTH-1:0][IDX_W-1:0] stg_dst,
  output logic [NUM_REGS-1:0]         busy_early,
  output logic [NUM_REGS-1:0]         busy_last
);
  localparam int unsigned LAST = DEPTH - 1;

  logic [DEPTH-1:0][NUM_REGS-1:0] stg_mask;

  for (genvar s = 0; s < DEPTH; s++) begin : g_dec
    hz_dst_decode #(
      .NUM_REGS(NUM_REGS),
      .IDX_W   (IDX_W)
    ) dec_i (
      .en  (stg_vld[s] && stg_wr[s]),
      .idx (stg_dst[s]),
      .mask(stg_mask[s])
    );
  end

  always_comb begin
    busy_early = '0;
    for (int s = 0; s < int'(LAST); s++) begin
      busy_early = busy_early | stg_mask[s];
    end
  end

  assign busy_last = stg_mask[LAST];
endmodule

// File: rtl/hz_scoreboard.sv
module hz_scoreboard #(
  parameter int unsigned NUM_REGS = hz_pkg::HZ_DEF_NUM_REGS,
  parameter int unsigned DEPTH    = hz_pkg::HZ_DEF_DEPTH,
  parameter int unsigned IDX_W    = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue_valid,
  input  logic [IDX_W-1:0] issue_rs1,
  input  logic [IDX_W-1:0] issue_rs2,
  input  logic [IDX_W-1:0] issue_rd,
  input  logic             issue_wr,
  output logic             stall,
  output logic             fwd_rs1,
  output logic             fwd_rs2
);
  import hz_pkg::*;

  logic [DEPTH-1:0]            stg_vld;
  logic [DEPTH-1:0]            stg_wr;
  logic [DEPTH-1:0][IDX_W-1:0] stg_dst;
  logic [NUM_REGS-1:0]         busy_early;
  logic [NUM_REGS-1:0]         busy_last;
  logic [NUM_REGS-1:0]         busy_all;
  logic [NUM_REGS-1:0]         rs1_hot;
  logic [NUM_REGS-1:0]         rs2_hot;
  logic [NUM_REGS-1:0]         rd_hot;
  hz_cause_e                   cause;

  hz_tag_pipe #(
    .DEPTH(DEPTH),
    .IDX_W(IDX_W)
  ) pipe_i (
    .clk    (clk),
    .rst    (rst),
    .in_vld (issue_valid && !stall),
    .in_wr  (issue_wr),
    .in_dst (issue_rd),
    .stg_vld(stg_vld),
    .stg_wr (stg_wr),
    .stg_dst(stg_dst)
  );

  hz_busy_merge #(
    .NUM_REGS(NUM_REGS),
    .IDX_W   (IDX_W),
    .DEPTH   (DEPTH)
  ) merge_i (
    .stg_vld   (stg_vld),
    .stg_wr    (stg_wr),
    .stg_dst   (stg_dst),
    .busy_early(busy_early),
    .busy_last (busy_last)
  );

  assign busy_all = busy_early | busy_last;

  hz_dst_decode #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) rs1_dec_i (
    .en(issue_valid), .idx(issue_rs1), .mask(rs1_hot));
  hz_dst_decode #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) rs2_dec_i (
    .en(issue_valid), .idx(issue_rs2), .mask(rs2_hot));
  hz_dst_decode #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) rd_dec_i (
    .en(issue_valid && issue_wr), .idx(issue_rd), .mask(rd_hot));

  always_comb begin
    cause = HZ_CLEAR;
    if (|((rs1_hot | rs2_hot) & busy_early)) cause = HZ_RAW;
    else if (|(rd_hot & busy_all))           cause = HZ_WAW;
  end

  assign stall   = (cause != HZ_CLEAR);
  assign fwd_rs1 = |(rs1_hot & busy_last);
  assign fwd_rs2 = |(rs2_hot & busy_last);
endmodule

// File: rtl/hz_scoreboard_chk.sv
module hz_scoreboard_chk #(
  parameter int unsigned IDX_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             issue_valid,
  input logic [IDX_W-1:0] issue_rs1,
  input logic [IDX_W-1:0] issue_rs2,
  input logic [IDX_W-1:0] issue_rd,
  input logic             issue_wr,
  input logic             stall,
  input logic             fwd_rs1,
  input logic             fwd_rs2,
  input logic             head_vld
);
  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !issue_valid |-> (!stall && !fwd_rs1 && !fwd_rs2));

  // R5
  zero_regs_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_rs1 == '0 && issue_rs2 == '0 && (issue_rd == '0 || !issue_wr)) |-> !stall);

  // R3
  fwd_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    (fwd_rs1 |-> issue_rs1 != '0) and (fwd_rs2 |-> issue_rs2 != '0));

  // R6
  bubble_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && stall) |=> !head_vld);

  // R4
  waw_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && !stall && issue_wr && issue_rd != '0) ##1
    (issue_valid && issue_wr && issue_rd == $past(issue_rd)) |-> stall);

  // R2
  raw_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && !stall && issue_wr && issue_rd != '0) ##1
    (issue_valid && issue_rs1 == $past(issue_rd)) |-> stall);
endmodule

bind hz_scoreboard hz_scoreboard_chk #(.IDX_W(IDX_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .issue_valid(issue_valid),
  .issue_rs1  (issue_rs1),
  .issue_rs2  (issue_rs2),
  .issue_rd   (issue_rd),
  .issue_wr   (issue_wr),
  .stall      (stall),
  .fwd_rs1    (fwd_rs1),
  .fwd_rs2    (fwd_rs2),
  .head_vld   (stg_vld[0])
);

// File: tb/hz_scoreboard_tb.sv
module hz_scoreboard_tb_top;
  localparam int DEPTH = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       issue_valid = 1'b0;
  logic [4:0] issue_rs1 = '0;
  logic [4:0] issue_rs2 = '0;
  logic [4:0] issue_rd = '0;
  logic       issue_wr = 1'b0;
  logic       stall, fwd_rs1, fwd_rs2;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  hz_scoreboard dut_i (
    .clk(clk), .rst(rst), .issue_valid(issue_valid),
    .issue_rs1(issue_rs1), .issue_rs2(issue_rs2), .issue_rd(issue_rd),
    .issue_wr(issue_wr), .stall(stall), .fwd_rs1(fwd_rs1), .fwd_rs2(fwd_rs2)
  );

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {stall,fwd1,fwd2} actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Drive one offer after the falling edge; outputs settle before the rising edge.
  task automatic step(input logic v, input logic [4:0] r1, input logic [4:0] r2,
                      input logic [4:0] rd, input logic wr);
    @(negedge clk);
    issue_valid = v; issue_rs1 = r1; issue_rs2 = r2; issue_rd = rd; issue_wr = wr;
    #1;
  endtask

  task automatic flush();
    for (int i = 0; i < DEPTH + 1; i++) step(1'b0, 5'd0, 5'd0, 5'd0, 1'b0);
  endtask

  task automatic t_reset();
    step(1'b1, 5'd0, 5'd0, 5'd5, 1'b1);
    step(1'b1, 5'd0, 5'd0, 5'd6, 1'b1);
    @(negedge clk); rst = 1'b1; issue_valid = 1'b0;
    @(negedge clk); rst = 1'b0;
    step(1'b1, 5'd5, 5'd6, 5'd5, 1'b1);
    chk("R1 empty after reset", {stall, fwd_rs1, fwd_rs2}, 3'b000);
    flush();
  endtask

  task automatic t_raw_chain(input bit use_rs2);
    step(1'b1, 5'd0, 5'd0, 5'd5, 1'b1);
    chk("R1 producer issues", {stall, fwd_rs1, fwd_rs2}, 3'b000);
    for (int k = 1; k <= DEPTH; k++) begin
      if (use_rs2) step(1'b1, 5'd0, 5'd5, 5'd3, 1'b1);
      else         step(1'b1, 5'd5, 5'd0, 5'd3, 1'b1);
      if (k < DEPTH)
        chk("R2 R7 early stage stalls reader", {stall, fwd_rs1, fwd_rs2}, 3'b100);
      else
        chk("R3 R7 last stage forwards", {stall, fwd_rs1, fwd_rs2},
            use_rs2 ? 3'b001 : 3'b010);
    end
    flush();
  endtask

  task automatic t_waw();
    step(1'b1, 5'd0, 5'd0, 5'd6, 1'b1);
    for (int k = 1; k <= DEPTH + 1; k++) begin
      step(1'b1, 5'd0, 5'd0, 5'd6, 1'b1);
      chk(k <= DEPTH ? "R4 same destination stalls" : "R4 released after retire",
          {stall, fwd_rs1, fwd_rs2}, k <= DEPTH ? 3'b100 : 3'b000);
    end
    flush();
  endtask

  task automatic t_zero();
    step(1'b1, 5'd0, 5'd0, 5'd0, 1'b1);
    step(1'b1, 5'd0, 5'd0, 5'd0, 1'b1);
    chk("R5 r0 destination never pending", {stall, fwd_rs1, fwd_rs2}, 3'b000);
    step(1'b1, 5'd0, 5'd0, 5'd9, 1'b0);
    step(1'b1, 5'd9, 5'd9, 5'd9, 1'b1);
    chk("R5 non-writer marks nothing", {stall, fwd_rs1, fwd_rs2}, 3'b000);
    flush();
  endtask

  task automatic t_bubble();
    step(1'b1, 5'd0, 5'd0, 5'd7, 1'b1);
    step(1'b1, 5'd7, 5'd0, 5'd9, 1'b1);
    chk("R6 dependent stalled", {stall, fwd_rs1, fwd_rs2}, 3'b100);
    step(1'b1, 5'd9, 5'd0, 5'd9, 1'b1);
    chk("R6 stalled destination not pending", {stall, fwd_rs1, fwd_rs2}, 3'b000);
    flush();
  endtask

  task automatic t_idle();
    step(1'b1, 5'd0, 5'd0, 5'd4, 1'b1);
    step(1'b0, 5'd4, 5'd4, 5'd4, 1'b1);
    chk("R8 invalid offer quiet (early)", {stall, fwd_rs1, fwd_rs2}, 3'b000);
    for (int k = 2; k < DEPTH; k++) step(1'b0, 5'd4, 5'd4, 5'd4, 1'b1);
    step(1'b0, 5'd4, 5'd4, 5'd4, 1'b1);
    chk("R8 invalid offer quiet (last)", {stall, fwd_rs1, fwd_rs2}, 3'b000);
    flush();
  endtask

  task automatic t_split();
    step(1'b1, 5'd0, 5'd0, 5'd10, 1'b1);
    for (int k = 1; k < DEPTH - 1; k++) step(1'b0, 5'd0, 5'd0, 5'd0, 1'b0);
    step(1'b1, 5'd0, 5'd0, 5'd11, 1'b1);
    chk("R9 unrelated writer issues", {stall, fwd_rs1, fwd_rs2}, 3'b000);
    step(1'b1, 5'd10, 5'd11, 5'd12, 1'b1);
    chk("R9 rs1 forwarded while rs2 stalls", {stall, fwd_rs1, fwd_rs2}, 3'b110);
    flush();
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_raw_chain(1'b0);
    t_raw_chain(1'b1);
    t_waw();
    t_zero();
    t_bubble();
    t_idle();
    t_split();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule